// File: doc/BRIEF.md
# I2C Register Slave with Deferred, Event-Aligned Commit

This block is the control-register port of a video processor. An external I2C master writes bytes into a shadow bank and reads them back from an active bank. The block answers at a fixed 7-bit device address and acts as both receiver and transmitter. Its internal subaddress pointer advances after each data byte. The system clock samples SCL and SDA through two-flop synchronisers, and the block drives SDA low through an output enable.

Writes never reach the active registers directly. The master first writes any byte to the store subaddress, which arms a commit. Every register belongs to one of three timing domains: main input vertical sync, secondary input vertical sync, or output cycle start. A register is copied from shadow to active only on the next event pulse of its own domain. Three status bytes show which domains still have a pending commit, so the master can tell when its new settings are in effect.

Top module: `i2c_commit_regs`

## Requirements
- R1: After reset, all active registers read 00h, all three pending flags are 0, and `sdaOe` is 0 (SDA released).
- R2: The block acknowledges address byte BCh (write) and BDh (read), which is 7-bit address 5Eh. For any other address it gives no acknowledge and keeps SDA released for the rest of that transaction.
- R3: A data byte written to subaddress a, with a below NUM_REGS, changes only the shadow copy. `regsOut` changes only in the clock cycle that follows an event pulse.
- R4: The subaddress pointer increments after every data byte, in write bursts and in read bursts.
- R5: Writing any value to subaddress FFh sets all three pending flags. Reading subaddress 80h returns the main-sync flag in bit 0, 81h the secondary-sync flag, and 82h the output-start flag. The other bits read 0.
- R6: The register at subaddress a belongs to domain a mod 3 (0 = main sync, 1 = secondary sync, 2 = output start). A one-cycle pulse on a domain's event input while its flag is pending copies shadow to active for that domain's registers only, and clears that flag.
- R7: An event pulse for a domain with no pending flag leaves its active registers unchanged.
- R8: Reads of subaddresses below NUM_REGS return the active value, not the shadow value. Reads of any other subaddress except 80h to 82h return 00h. Writes to unmapped subaddresses are acknowledged and discarded.
- R9: In a read burst, the slave sends bytes MSB first while the master acknowledges. After the master's NACK it releases SDA, and a later transaction proceeds normally.
- R10: `sdaOe` changes only while the synchronised SCL is low.
- R11: A store command issued while a domain is still pending leaves that domain pending. The next event then copies the latest shadow contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | I2C clock line as seen on the pin |
| sdaIn | input | 1 | I2C data line as seen on the pin |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain) |
| vsyncMain | input | 1 | One-cycle pulse: main input vertical sync (domain 0) |
| vsyncSec | input | 1 | One-cycle pulse: secondary input vertical sync (domain 1) |
| outStart | input | 1 | One-cycle pulse: output cycle start (domain 2) |
| regsOut | output | NUM_REGS*8 | Active bank; byte a sits at bits a*8+7 to a*8 |

## Verification
Bus responses go through the synchroniser, the edge detector and the byte FSM, so they appear about four system clocks after the SCL edge that causes them. The bench therefore samples ACK and read bits halfway through SCL high, well past that delay. A commit is registered on the clock edge where the event pulse is high. `regsOut` is checked at the falling clock edge right after that pulse, and checked again before the pulse, to confirm nothing moved early. Status flags are read back over the bus after each store and after each event, so pending state is always observed at the ports.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int NUM_DOMAINS = 3;

  typedef enum logic [1:0] {
    DOM_MAIN = 2'd0,
    DOM_SEC  = 2'd1,
    DOM_OUT  = 2'd2
  } domain_e;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic       loadSub;
    logic       wrByte;
    logic       incSub;
    logic [7:0] byteVal;
  } busStrobes_t;

  function automatic domain_e domainOf(input int idx);
    return domain_e'(2'(idx % NUM_DOMAINS));
  endfunction
endpackage

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5E
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [7:0]  rdByte,
  output busStrobes_t strb,
  output logic        sdaOe,
  output logic        sclLevel
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_SUB, ST_ACK_SUB,
    ST_WDATA, ST_ACK_W, ST_RDATA, ST_RACK
  } state_e;

  logic [1:0] sclSync, sdaSync;
  logic       sclD, sdaD;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet;
  state_e     state;
  logic [3:0] bitCnt;
  logic [7:0] shiftIn, txShift;
  logic       rwBit, mAck;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];
  assign sclLevel = sclS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      shiftIn <= '0;
      txShift <= '0;
      rwBit   <= 1'b0;
      mAck    <= 1'b0;
      strb    <= '0;
    end else begin
      strb <= '0;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
      end else if (stopDet) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftIn <= {shiftIn[6:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (shiftIn[7:1] == DEV_ADDR) begin
                  state <= ST_ACK_ADDR;
                  rwBit <= shiftIn[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_SUB) begin
                state        <= ST_ACK_SUB;
                strb.loadSub <= 1'b1;
                strb.byteVal <= shiftIn;
              end else begin
                state        <= ST_ACK_W;
                strb.wrByte  <= 1'b1;
                strb.byteVal <= shiftIn;
              end
            end
          end
          ST_ACK_ADDR: if (sclFall) begin
            if (rwBit) begin
              state   <= ST_RDATA;
              txShift <= rdByte;
            end else begin
              state <= ST_SUB;
            end
          end
          ST_ACK_SUB, ST_ACK_W: if (sclFall) state <= ST_WDATA;
          ST_RDATA: begin
            if (sclRise && bitCnt < 4'd8) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                bitCnt      <= '0;
                state       <= ST_RACK;
                strb.incSub <= 1'b1;
              end else begin
                txShift <= {txShift[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                state   <= ST_RDATA;
                txShift <= rdByte;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_ACK_ADDR, ST_ACK_SUB, ST_ACK_W: sdaOe = 1'b1;
      ST_RDATA:                          sdaOe = ~txShift[7];
      default:                           sdaOe = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2cr_datapath.sv
module i2cr_datapath
  import i2cr_pkg::*;
#(
  parameter int         NUM_REGS    = 32,
  parameter logic [7:0] STORE_SUB   = 8'hFF,
  parameter logic [7:0] STATUS_BASE = 8'h80
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobes_t           strb,
  input  logic [NUM_DOMAINS-1:0] evt,
  output logic [7:0]            rdByte,
  output logic [NUM_REGS*8-1:0] regsOut,
  output logic [NUM_DOMAINS-1:0] pending,
  output logic                  storeHit
);
  localparam int IDXW = $clog2(NUM_REGS);

  logic [7:0] subAddr;
  logic [7:0] shadow [NUM_REGS];
  logic [7:0] active [NUM_REGS];

  assign storeHit = strb.wrByte && (subAddr == STORE_SUB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subAddr <= '0;
    end else if (strb.loadSub) begin
      subAddr <= strb.byteVal;
    end else if (strb.wrByte || strb.incSub) begin
      subAddr <= subAddr + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end else begin
        if (strb.wrByte && subAddr == 8'(i)) shadow[i] <= strb.byteVal;
        if (evt[domainOf(i)] && pending[domainOf(i)]) active[i] <= shadow[i];
      end
    end
  end

  generate
    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_pend
      always_ff @(posedge clk) begin
        if (!rstN) pending[d] <= 1'b0;
        else       pending[d] <= storeHit | (pending[d] & ~evt[d]);
      end
    end
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
      assign regsOut[i*8 +: 8] = active[i];
    end
  endgenerate

  always_comb begin
    rdByte = '0;
    if (int'(subAddr) < NUM_REGS) begin
      rdByte = active[subAddr[IDXW-1:0]];
    end else if (subAddr == STATUS_BASE) begin
      rdByte = {7'b0, pending[DOM_MAIN]};
    end else if (subAddr == STATUS_BASE + 8'd1) begin
      rdByte = {7'b0, pending[DOM_SEC]};
    end else if (subAddr == STATUS_BASE + 8'd2) begin
      rdByte = {7'b0, pending[DOM_OUT]};
    end
  end
endmodule

// File: rtl/i2c_commit_regs.sv
module i2c_commit_regs
  import i2cr_pkg::*;
#(
  parameter int         NUM_REGS = 32,
  parameter logic [6:0] DEV_ADDR = 7'h5E
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic                  vsyncMain,
  input  logic                  vsyncSec,
  input  logic                  outStart,
  output logic [NUM_REGS*8-1:0] regsOut
);
  busStrobes_t            strb;
  logic [7:0]             rdByte;
  logic [NUM_DOMAINS-1:0] evt;
  logic [NUM_DOMAINS-1:0] pending;
  logic                   storeHit;
  logic                   sclLevel;

  assign evt = {outStart, vsyncSec, vsyncMain};

  i2cr_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .strb(strb), .sdaOe(sdaOe), .sclLevel(sclLevel)
  );

  i2cr_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evt(evt),
    .rdByte(rdByte), .regsOut(regsOut), .pending(pending), .storeHit(storeHit)
  );
endmodule

// File: rtl/i2cr_check.sv
module i2cr_check
  import i2cr_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclLevel,
  input logic                   sdaOe,
  input logic [NUM_DOMAINS-1:0] evt,
  input logic [NUM_DOMAINS-1:0] pending,
  input logic                   storeHit,
  input logic [NUM_REGS*8-1:0]  regsOut
);
  // R10: open-drain enable moves only while SCL is low
  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLevel);

  // R3: active bank changes only right after an event pulse
  a_r3_active_after_event: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regsOut) |-> $past(|evt));

  // R11: store while pending leaves every domain pending
  a_r11_store_pends_all: assert property (@(posedge clk) disable iff (!rstN)
    storeHit |=> (pending == '1));

  generate
    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
      // R5: a flag only rises after a store command
      a_r5_flag_from_store: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pending[d]) |-> $past(storeHit));
      // R6: an event without a simultaneous store clears its flag
      a_r6_event_clears: assert property (@(posedge clk) disable iff (!rstN)
        (evt[d] && !storeHit) |=> !pending[d]);
    end
  endgenerate
endmodule

bind i2c_commit_regs i2cr_check #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sdaOe(sdaOe), .evt(evt),
  .pending(pending), .storeHit(storeHit), .regsOut(regsOut)
);

// File: tb/sim_i2c_commit_regs.sv
module sim_i2c_commit_regs;
  localparam int CLK_PERIOD = 10;
  localparam int H = 10;          // system clocks per SCL half period
  localparam int NR = 32;
  localparam int NV = 6;
  // {subaddress, data}
  localparam logic [15:0] VEC [NV] = '{
    {8'h00, 8'hA5}, {8'h04, 8'h3C}, {8'h08, 8'h81},
    {8'h0D, 8'h5A}, {8'h1F, 8'hC3}, {8'h11, 8'h7E}
  };

  logic clk = 0, rstN = 0;
  logic sclM = 1, sdaM = 1;
  logic vMain = 0, vSec = 0, oStart = 0;
  logic sdaOe;
  logic [NR*8-1:0] regsOut;
  wire  sdaBus = sdaM & ~sdaOe;

  int total = 0, bad = 0;
  logic [7:0] shdM [NR];
  logic [7:0] actM [NR];
  logic [2:0] pendM;
  logic [7:0] rbuf [4];
  logic ackBit;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_commit_regs #(.NUM_REGS(NR)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .vsyncMain(vMain), .vsyncSec(vSec), .outStart(oStart), .regsOut(regsOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startC();
    sdaM = 1; tick(H); sclM = 1; tick(H); sdaM = 0; tick(H); sclM = 0; tick(H);
  endtask

  task automatic stopC();
    sdaM = 0; tick(H); sclM = 1; tick(H); sdaM = 1; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(H); sclM = 1; tick(H); sclM = 0;
    end
    sdaM = 1; tick(H); sclM = 1; tick(H/2); ack = ~sdaBus; tick(H/2); sclM = 0;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); sclM = 1; tick(H/2); b[i] = sdaBus; tick(H/2); sclM = 0;
    end
    sdaM = ackIt ? 1'b0 : 1'b1; tick(H); sclM = 1; tick(H); sclM = 0; sdaM = 1;
  endtask

  task automatic wrBytes(input logic [7:0] sub, input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input int n);
    logic a;
    logic [7:0] dv [3];
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    startC();
    sendByte(8'hBC, a); chk("R2 write address ack", a, 1);
    sendByte(sub, a);
    for (int k = 0; k < n; k++) begin
      sendByte(dv[k], a);
      if (int'(sub) + k < NR) shdM[int'(sub) + k] = dv[k];
      if (sub + 8'(k) == 8'hFF) pendM = 3'b111;
    end
    stopC();
  endtask

  task automatic rdBytes(input logic [7:0] sub, input int n);
    logic a;
    startC();
    sendByte(8'hBC, a);
    sendByte(sub, a);
    sdaM = 1; tick(H); sclM = 1; tick(H); sdaM = 0; tick(H); sclM = 0; tick(H);
    sendByte(8'hBD, a); chk("R2 read address ack", a, 1);
    for (int k = 0; k < n; k++) recvByte(k != n-1, rbuf[k]);
    stopC();
  endtask

  task automatic pulse(input int d);
    if (d == 0) vMain = 1; else if (d == 1) vSec = 1; else oStart = 1;
    tick(1);
    vMain = 0; vSec = 0; oStart = 0;
    if (pendM[d]) begin
      for (int i = 0; i < NR; i++) if (i % 3 == d) actM[i] = shdM[i];
      pendM[d] = 0;
    end
  endtask

  task automatic chkBank(input string req);
    logic ok = 1;
    for (int i = 0; i < NR; i++) begin
      if (regsOut[i*8 +: 8] !== actM[i]) begin
        ok = 0;
        $display("FAIL %s: reg %0h actual=%0h expected=%0h", req, i, regsOut[i*8 +: 8], actM[i]);
      end
    end
    total++;
    if (!ok) bad++;
  endtask

  task automatic chkStatus(input string req);
    rdBytes(8'h80, 3);
    for (int d = 0; d < 3; d++) chk(req, {24'b0, rbuf[d]}, {31'b0, pendM[d]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin shdM[i] = 0; actM[i] = 0; end
    pendM = 0;
    tick(5); rstN = 1; tick(5);

    // R1 reset state
    chk("R1 sda released", sdaOe, 0);
    chkBank("R1 active zero");
    chkStatus("R1 flags clear");

    // table walk: R3 shadow only, R5 flags, R6 per-domain commit
    for (int v = 0; v < NV; v++) begin
      logic [7:0] sub;
      int dom;
      sub = VEC[v][15:8];
      dom = int'(sub) % 3;
      wrBytes(sub, VEC[v][7:0], 8'h00, 8'h00, 1);
      chkBank("R3 shadow not active");
      wrBytes(8'hFF, 8'h5C, 8'h00, 8'h00, 1);
      chkStatus("R5 flags after store");
      pulse((dom + 1) % 3); chkBank("R6 other domain commit");
      chk("R6 own reg waits", regsOut[int'(sub)*8 +: 8], actM[int'(sub)]);
      pulse(dom); chkBank("R6 own domain commit");
      chk("R6 value active", regsOut[int'(sub)*8 +: 8], VEC[v][7:0]);
      pulse((dom + 2) % 3);
      chkStatus("R6 flags cleared");
    end

    // R2 foreign address not acknowledged
    startC(); sendByte(8'hA0, ackBit); chk("R2 foreign nack", ackBit, 0);
    sendByte(8'h12, ackBit); chk("R2 stays released", sdaOe, 0); stopC();

    // R4/R8 burst crossing into unmapped space
    wrBytes(8'h1E, 8'h11, 8'h22, 8'h33, 3);
    wrBytes(8'hFF, 8'h00, 8'h00, 8'h00, 1);
    pulse(0); pulse(1); pulse(2);
    chkBank("R4 burst commit");
    rdBytes(8'h1E, 3);
    chk("R4 read first", rbuf[0], 8'h11);
    chk("R4 read increments", rbuf[1], 8'h22);
    chk("R8 unmapped reads zero", rbuf[2], 8'h00);
    chk("R9 released after nack", sdaOe, 0);

    // R7/R8 event without store; read returns active
    wrBytes(8'h03, 8'h44, 8'h00, 8'h00, 1);
    pulse(0); chkBank("R7 no pending no change");
    rdBytes(8'h03, 1); chk("R8 read active not shadow", rbuf[0], actM[3]);

    // R11 store twice, latest shadow wins
    wrBytes(8'hFF, 8'h01, 8'h00, 8'h00, 1);
    wrBytes(8'h00, 8'h99, 8'h00, 8'h00, 1);
    wrBytes(8'hFF, 8'h02, 8'h00, 8'h00, 1);
    chkStatus("R11 still pending");
    pulse(0);
    chk("R11 latest value", regsOut[7:0], 8'h99);
    chk("R11 reg3 also", regsOut[3*8 +: 8], 8'h44);
    pulse(1); pulse(2);

    // R9 new transaction after a read
    rdBytes(8'h00, 2);
    chk("R9 read again", rbuf[0], 8'h99);
    chk("R9 second byte", rbuf[1], actM[1]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule